// File: doc/BRIEF.md
# Keyed Watchdog Arming Controller

This block guards the arming of a timer that runs as a 64-bit watchdog. It watches register writes aimed at one control address. Each write carries an enable flag and a 16-bit key. The watchdog only arms after two keys arrive in the right order with the enable flag set. The first key puts the unit in a waiting (pre-armed) state, and the second key arms it. While the unit is armed, the `wd_run` output tells the 64-bit counter to run.

Once the unit is armed, software cannot disarm it. To service it, software writes the first key and then the second key. This pulses `cnt_restart` so the counter starts again. A system reset request is raised by any armed write whose key breaks that pairing, or by the counter reporting that it reached its period. The request stays high until the block's reset input is asserted.

The whole unit only acts while two conditions hold: the timer mode field selects watchdog operation, and both counter halves are out of reset.

Top module: `wdog_key_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wd_run`, `sys_rst_req` and `cnt_restart` are 0 and the unit is unarmed. Release passes through a two-stage synchronizer.
- R2: A write to the control address (default 0x28) with key 0xA5C6 in bits [31:16] and enable bit 14 set moves an unarmed unit to pre-armed. `wd_run` stays 0.
- R3: From pre-armed, a write with key 0xDA7E and bit 14 set arms the unit. `wd_run` reads 1 from the cycle after that write.
- R4: While the unit is unarmed or pre-armed, any other key, or bit 14 clear, sends it back to unarmed without raising `sys_rst_req`. Writing key 0xA5C6 with bit 14 set again while pre-armed keeps it pre-armed.
- R5: While the unit is armed, a write whose key is neither the expected next service key nor 0xA5C6 raises `sys_rst_req` in the following cycle. The expected key is 0xA5C6 first, then 0xDA7E.
- R6: While the unit is armed, `cnt_match` high raises `sys_rst_req` in the following cycle.
- R7: `sys_rst_req` and `wd_run` stay high until `rst_n` is asserted. Bit 14 is ignored once the unit is armed.
- R8: While the unit is armed, key 0xA5C6 followed by key 0xDA7E pulses `cnt_restart` for exactly one cycle after the second write, without a reset request.
- R9: Writes to any address other than the control address change nothing.
- R10: Writes and `cnt_match` are ignored unless `mode_sel` equals 2 and both bits of `half_run` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data: key [31:16], enable bit 14 |
| mode_sel | input | 2 | Timer mode field (2 = watchdog) |
| half_run | input | 2 | Out-of-reset flags of the two counter halves |
| cnt_match | input | 1 | Counter reached its period |
| wd_run | output | 1 | Watchdog armed, counter runs |
| cnt_restart | output | 1 | One-cycle service pulse restarting the counter |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
The bench uses the default parameters: 8-bit addresses, 32-bit data, control offset 0x28, and a two-stage reset synchronizer. With these values the real keys can reach the decoder directly. The random stimulus is biased toward the two keys, the control address and a valid mode, so the armed and service-pending states come up often. A reset every 64 vectors keeps the sticky request from hiding the later behaviour. Directed cases cover:
- every way of falling back out of pre-armed;
- a foreign-address write between the two keys;
- gating by mode and by the half-reset flags.

// File: rtl/wdog_key_pkg.sv
package wdog_key_pkg;
  typedef enum logic [1:0] {
    WD_IDLE     = 2'd0,
    WD_PRE      = 2'd1,
    WD_ARMED    = 2'd2,
    WD_SVC_HALF = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdog_wr_decode.sv
module wdog_wr_decode #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFFS = 'h28,
  parameter int EN_BIT = 14,
  parameter int KEY_LSB = 16,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_GO = 16'hDA7E,
  parameter int MODE_W = 2,
  parameter logic [MODE_W-1:0] WD_MODE = 2'd2,
  parameter int HALVES = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [HALVES-1:0] half_run,
  output logic              gate_ok,
  output logic              hit,
  output logic              en_bit,
  output logic              key_arm,
  output logic              key_go
);
  logic [KEY_W-1:0] key_f;
  logic             unused_data;

  assign key_f       = wr_data[KEY_LSB +: KEY_W];
  assign unused_data = ^wr_data;
  assign gate_ok     = (mode_sel == WD_MODE) && (&half_run);
  assign hit         = wr_en && (wr_addr == CTRL_OFFS) && gate_ok;
  assign en_bit      = wr_data[EN_BIT];
  assign key_arm     = (key_f == KEY_ARM);
  assign key_go      = (key_f == KEY_GO);
endmodule

// File: rtl/wdog_arm_fsm.sv
module wdog_arm_fsm
  import wdog_key_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic en_bit,
  input  logic key_arm,
  input  logic key_go,
  output logic run,
  output logic kick,
  output logic bad_key
);
  wd_state_e state_q, state_d;
  logic      kick_d;

  always_comb begin
    state_d = state_q;
    kick_d  = 1'b0;
    bad_key = 1'b0;
    if (hit) begin
      unique case (state_q)
        WD_IDLE: if (en_bit && key_arm) state_d = WD_PRE;
        WD_PRE: begin
          if (en_bit && key_go)       state_d = WD_ARMED;
          else if (en_bit && key_arm) state_d = WD_PRE;
          else                        state_d = WD_IDLE;
        end
        WD_ARMED: begin
          if (key_arm) state_d = WD_SVC_HALF;
          else         bad_key = 1'b1;
        end
        WD_SVC_HALF: begin
          if (key_go) begin
            state_d = WD_ARMED;
            kick_d  = 1'b1;
          end else if (!key_arm) begin
            bad_key = 1'b1;
          end
        end
        default: state_d = WD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      kick    <= 1'b0;
    end else begin
      state_q <= state_d;
      kick    <= kick_d;
    end
  end

  assign run = (state_q == WD_ARMED) || (state_q == WD_SVC_HALF);

  // R3
  arm_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(hit && key_go && en_bit));

  // R7
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);

  // R9
  no_hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(state_q));
endmodule

// File: rtl/wdog_rst_hold.sv
module wdog_rst_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic bad_key,
  input  logic cnt_match,
  input  logic gate_ok,
  input  logic run,
  output logic req
);
  logic set_d;

  always_comb set_d = bad_key || (gate_ok && cnt_match && run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     req <= 1'b0;
    else if (set_d) req <= 1'b1;
  end

  // R7
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> req);

  // R5 R6
  req_only_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(run));
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFFS = 'h28,
  parameter int MODE_W = 2,
  parameter int HALVES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [HALVES-1:0] half_run,
  input  logic              cnt_match,
  output logic              wd_run,
  output logic              cnt_restart,
  output logic              sys_rst_req
);
  logic [SYNC_STAGES-1:0] rst_sync;
  logic rst_i_n;
  logic gate_ok, hit, en_bit, key_arm, key_go, bad_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync[SYNC_STAGES-1];

  wdog_wr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFFS(CTRL_OFFS),
    .MODE_W(MODE_W), .HALVES(HALVES)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_sel(mode_sel), .half_run(half_run), .gate_ok(gate_ok),
    .hit(hit), .en_bit(en_bit), .key_arm(key_arm), .key_go(key_go)
  );

  wdog_arm_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .hit(hit), .en_bit(en_bit),
    .key_arm(key_arm), .key_go(key_go), .run(wd_run),
    .kick(cnt_restart), .bad_key(bad_key)
  );

  wdog_rst_hold u_hold (
    .clk(clk), .rst_n(rst_i_n), .bad_key(bad_key), .cnt_match(cnt_match),
    .gate_ok(gate_ok), .run(wd_run), .req(sys_rst_req)
  );

  // R10
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!gate_ok && !sys_rst_req) |=> !sys_rst_req);

  // R8
  kick_clean_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    cnt_restart |=> !cnt_restart);
endmodule

// File: tb/wdog_key_seq_tb.sv
module wdog_key_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KA = 16'hA5C6;
  localparam logic [15:0] KB = 16'hDA7E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] mode_sel = 2'd2;
  logic [1:0] half_run = 2'b11;
  logic cnt_match = 1'b0;
  logic wd_run, cnt_restart, sys_rst_req;

  int vec_cnt = 0;
  int err_cnt = 0;
  int m_st = 0;
  bit m_req = 0;
  bit m_kick = 0;

  wdog_key_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_sel(mode_sel), .half_run(half_run),
    .cnt_match(cnt_match), .wd_run(wd_run), .cnt_restart(cnt_restart),
    .sys_rst_req(sys_rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [15:0] key, input bit en);
    return {key, 1'b0, en, 14'h0};
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input logic [1:0] md, input logic [1:0] hr, input bit m);
    bit ok, hit, en, ka, kb;
    int old;
    ok = (md == 2'd2) && (hr == 2'b11);
    hit = we && (a == 8'h28) && ok;
    en = d[14];
    ka = (d[31:16] == KA);
    kb = (d[31:16] == KB);
    old = m_st;
    m_kick = 0;
    if (hit) begin
      case (old)
        0: if (en && ka) m_st = 1;
        1: m_st = (en && kb) ? 2 : ((en && ka) ? 1 : 0);
        2: if (ka) m_st = 3; else m_req = 1;
        default: if (kb) begin m_st = 2; m_kick = 1; end
                 else if (!ka) m_req = 1;
      endcase
    end
    if (ok && m && old >= 2) m_req = 1;
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input logic [1:0] md, input logic [1:0] hr, input bit m,
                      input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; mode_sel = md; half_run = hr; cnt_match = m;
    @(posedge clk);
    #1;
    model(we, a, d, md, hr, m);
    chk(wd_run, (m_st >= 2), tag, "wd_run");
    chk(sys_rst_req, m_req, tag, "sys_rst_req");
    chk(cnt_restart, m_kick, tag, "cnt_restart");
  endtask

  task automatic wr(input logic [31:0] d, input string tag);
    step(1'b1, 8'h28, d, 2'd2, 2'b11, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 32'h0, 2'd2, 2'b11, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; cnt_match = 0;
    #1;
    // R1 outputs clear while reset is held
    chk(wd_run, 1'b0, "R1", "wd_run");
    chk(sys_rst_req, 1'b0, "R1", "sys_rst_req");
    chk(cnt_restart, 1'b0, "R1", "cnt_restart");
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_st = 0; m_req = 0; m_kick = 0;
    repeat (3) idle("R1");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    err_cnt++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    logic [31:0] rnd;
    rnd = $urandom(32'd7);
    do_reset();
    // R2 then R3
    wr(mk(KA, 1), "R2");
    wr(mk(KB, 1), "R3");
    // R8 service with enable clear (R7 enable ignored when armed)
    wr(mk(KA, 0), "R8");
    wr(mk(KB, 0), "R8");
    idle("R8");
    // R5 bad key while armed
    wr(mk(16'h0000, 1), "R5");
    idle("R7");
    wr(mk(KA, 1), "R7");
    wr(mk(KB, 1), "R7");
    // R4 fallback paths
    do_reset();
    wr(mk(KA, 1), "R4");
    wr(mk(16'h1234, 1), "R4");
    wr(mk(KB, 1), "R4");
    wr(mk(KA, 1), "R4");
    wr(mk(KB, 0), "R4");
    wr(mk(KB, 1), "R4");
    wr(mk(KA, 1), "R4");
    wr(mk(KA, 1), "R4");
    wr(mk(KB, 1), "R4");
    // R5 wrong key in service half
    wr(mk(KA, 1), "R5");
    wr(mk(16'h5555, 1), "R5");
    // R9 foreign address between keys
    do_reset();
    wr(mk(KA, 1), "R9");
    step(1'b1, 8'h24, mk(16'h0, 0), 2'd2, 2'b11, 1'b0, "R9");
    wr(mk(KB, 1), "R9");
    step(1'b1, 8'h2C, mk(16'h0, 1), 2'd2, 2'b11, 1'b0, "R9");
    // R10 gating
    do_reset();
    step(1'b1, 8'h28, mk(KA, 1), 2'd1, 2'b11, 1'b0, "R10");
    wr(mk(KB, 1), "R10");
    wr(mk(KA, 1), "R10");
    step(1'b1, 8'h28, mk(KB, 1), 2'd2, 2'b01, 1'b0, "R10");
    wr(mk(KB, 1), "R10");
    step(1'b0, 8'h00, 32'h0, 2'd3, 2'b11, 1'b1, "R10");
    step(1'b1, 8'h28, mk(16'h0, 1), 2'd2, 2'b10, 1'b0, "R10");
    // R6 counter match
    step(1'b0, 8'h00, 32'h0, 2'd2, 2'b11, 1'b1, "R6");
    idle("R6");
    // random phase
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] key;
      logic [7:0] a;
      logic [1:0] md, hr;
      bit we, en, m;
      if ((i % 64) == 63) do_reset();
      rnd = $urandom;
      case (rnd[2:0])
        3'd0, 3'd1, 3'd2: key = KA;
        3'd3, 3'd4, 3'd5: key = KB;
        3'd6: key = 16'h0000;
        default: key = rnd[31:16];
      endcase
      en = (rnd[5:3] != 3'd0);
      we = (rnd[7:6] != 2'd0);
      a = (rnd[10:8] != 3'd0) ? 8'h28 : {rnd[15:12], 4'h4};
      md = (rnd[13:11] != 3'd0) ? 2'd2 : 2'd0;
      hr = (rnd[17:15] != 3'd0) ? 2'b11 : 2'b10;
      m = (rnd[23:18] == 6'd0);
      step(we, a, mk(key, en), md, hr, m, "R10 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule